// File: doc/BRIEF.md
# Indirect Configuration and IO Port Front End

This block sits between a host register interface and a downstream bus that carries configuration and IO-space transactions. Software first writes a 32-bit pointer into a configuration-address register. It then reaches the selected location through one of two 4-byte data windows. Each window access becomes one downstream request. The request address is the stored pointer with its two low bits cleared, combined with the byte position of the access inside the window.

The configuration window places bytes in little-endian lane order. The IO window places them in big-endian lane order on the host side. Byte, halfword and word accesses are accepted at naturally aligned positions. Any other access gets an error response and sends nothing downstream.

The host side has one outstanding access at a time. An access that goes downstream completes only after the downstream side answers.

Top module: `pcfg_front`

## Requirements
- R1: A 4-byte write at host offset 0x064 stores all 32 bits of the pointer. A 4-byte read there returns the stored value exactly, low two bits included. The pointer resets to 0.
- R2: Any access to the pointer that is not a 4-byte access at offset 0x064 gets an error response, and the stored value is left unchanged.
- R3: An access to the configuration window (0x068 to 0x06B, byte position k) issues a downstream request with type bit 0 and address (pointer & ~3) | k. This happens whatever the value of pointer bit 31.
- R4: An access to the IO window (0x06C to 0x06F, byte position k) issues a downstream request with type bit 1 and address (pointer & ~3) + k.
- R5: The size code on h_size is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes; code 3 is illegal. In either window, a 1-byte access is legal at any k, a 2-byte access only at k = 0 or 2, and a 4-byte access only at k = 0. An illegal access gets an error response and issues no downstream request.
- R6: The downstream byte enables select exactly the n lanes k to k+n-1, where lane j is bits [8j+7:8j] of the downstream data.
- R7: Configuration data is carried little-endian. Host data byte i (byte 0 is bits [7:0]) travels on lane k+i in both directions.
- R8: IO data is carried big-endian. Host data byte i travels on lane k+n-1-i in both directions.
- R9: A downstream access gives a one-cycle host response in the cycle after the cycle that samples d_rsp_valid, never earlier. h_ready is low from the cycle after acceptance until the cycle after the response. Each access drives d_req_valid for exactly one cycle.
- R10: An access whose word offset is none of 0x064, 0x068 or 0x06C gets an error response and issues no downstream request.
- R11: Out of reset, h_ready is 1 and h_rsp_valid and d_req_valid are 0. A local or error access answers in the cycle after acceptance. Reads of error accesses and all write responses return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access request, taken when h_ready is high |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | HA_W | Host byte offset |
| h_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| h_wdata | input | 32 | Host write value, right-justified |
| h_ready | output | 1 | Block is idle and can take an access |
| h_rsp_valid | output | 1 | One-cycle host completion |
| h_rsp_err | output | 1 | Completion reports an illegal access |
| h_rdata | output | 32 | Read value, right-justified |
| d_req_valid | output | 1 | One-cycle downstream request |
| d_req_io | output | 1 | Request type: 1 for IO, 0 for configuration |
| d_req_we | output | 1 | Downstream write flag |
| d_req_addr | output | 32 | Downstream byte address |
| d_req_be | output | 4 | Downstream byte enables |
| d_req_wdata | output | 32 | Downstream write data in lane order |
| d_rsp_valid | input | 1 | Downstream completion |
| d_rsp_rdata | input | 32 | Downstream read data in lane order |

## Verification
The assertions assume that the downstream side raises d_rsp_valid only while a request is outstanding, once per request, and never in the cycle of d_req_valid's rising edge beyond the first answer. They also assume the host holds h_req only for the cycle in which it is taken. The stimulus drives each access for exactly one accepted cycle. It answers each downstream request once, after a chosen latency of zero to three cycles, and keeps d_rsp_valid low at every other time. Illegal sizes, misaligned positions and unmapped offsets are driven through the same single-cycle host request.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_BAD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_CFG  = 2'd2,
    TGT_IO   = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  function automatic logic [2:0] size_bytes(size_e s);
    case (s)
      SZ_B:    return 3'd1;
      SZ_H:    return 3'd2;
      SZ_W:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pcfg_ptr_reg.sv
module pcfg_ptr_reg #(
  parameter int            W       = 32,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= wr_data;
  end

endmodule

// File: rtl/pcfg_decode.sv
module pcfg_decode
  import pcfg_pkg::*;
#(
  parameter int             HA_W    = 12,
  parameter logic [HA_W-1:0] PTR_OFS = 12'h064,
  parameter logic [HA_W-1:0] CFG_OFS = 12'h068,
  parameter logic [HA_W-1:0] IO_OFS  = 12'h06C
) (
  input  logic [HA_W-1:0] addr,
  input  size_e           size,
  output tgt_e            tgt,
  output logic            legal,
  output logic [1:0]      lane
);

  logic [HA_W-1:0] word;
  logic            aligned;

  assign word = {addr[HA_W-1:2], 2'b00};
  assign lane = addr[1:0];

  always_comb begin
    case (size)
      SZ_B:    aligned = 1'b1;
      SZ_H:    aligned = (lane[0] == 1'b0);
      SZ_W:    aligned = (lane == 2'd0);
      default: aligned = 1'b0;
    endcase
  end

  always_comb begin
    tgt   = TGT_NONE;
    legal = 1'b0;
    if (word == PTR_OFS) begin
      tgt   = TGT_PTR;
      legal = (size == SZ_W) && (lane == 2'd0);
    end else if (word == CFG_OFS) begin
      tgt   = TGT_CFG;
      legal = aligned;
    end else if (word == IO_OFS) begin
      tgt   = TGT_IO;
      legal = aligned;
    end
  end

endmodule

// File: rtl/pcfg_lane_map.sv
// Moves bytes between a right-justified host value and bus lanes.
// BIG selects the lane order, UNPACK selects the direction.
module pcfg_lane_map
  import pcfg_pkg::*;
#(
  parameter bit BIG    = 1'b0,
  parameter bit UNPACK = 1'b0
) (
  input  size_e          size,
  input  logic [1:0]     ofs,
  input  logic [DW-1:0]  din,
  output logic [LANES-1:0] lane_en,
  output logic [DW-1:0]  dout
);

  logic signed [3:0] nb;
  logic signed [3:0] k;

  assign nb = $signed({1'b0, size_bytes(size)});
  assign k  = $signed({2'b00, ofs});

  for (genvar p = 0; p < LANES; p++) begin : g_pos
    localparam logic signed [3:0] PS = 4'(p);
    logic signed [3:0] src;
    logic              hit;

    if (UNPACK) begin : g_un
      // p is a host byte; src is the bus lane it comes from
      if (BIG) begin : g_be
        assign src = k + nb - 4'sd1 - PS;
      end else begin : g_le
        assign src = k + PS;
      end
      assign hit = (PS < nb);
    end else begin : g_pk
      // p is a bus lane; src is the host byte it carries
      if (BIG) begin : g_be
        assign src = k + nb - 4'sd1 - PS;
      end else begin : g_le
        assign src = PS - k;
      end
      assign hit = (src >= 4'sd0) && (src < nb);
    end

    assign lane_en[p]     = hit;
    assign dout[8*p +: 8] = hit ? din[8*src[1:0] +: 8] : 8'h00;
  end

endmodule

// File: rtl/pcfg_front.sv
module pcfg_front
  import pcfg_pkg::*;
#(
  parameter int              HA_W    = 12,
  parameter logic [HA_W-1:0] PTR_OFS = 12'h064,
  parameter logic [HA_W-1:0] CFG_OFS = 12'h068,
  parameter logic [HA_W-1:0] IO_OFS  = 12'h06C,
  parameter logic [31:0]     PTR_RST = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_req,
  input  logic            h_we,
  input  logic [HA_W-1:0] h_addr,
  input  logic [1:0]      h_size,
  input  logic [31:0]     h_wdata,
  output logic            h_ready,
  output logic            h_rsp_valid,
  output logic            h_rsp_err,
  output logic [31:0]     h_rdata,
  output logic            d_req_valid,
  output logic            d_req_io,
  output logic            d_req_we,
  output logic [31:0]     d_req_addr,
  output logic [3:0]      d_req_be,
  output logic [31:0]     d_req_wdata,
  input  logic            d_rsp_valid,
  input  logic [31:0]     d_rsp_rdata
);

  state_e      state;
  tgt_e        tgt;
  logic        legal;
  logic [1:0]  lane;
  size_e       hsize;
  logic        accept;
  logic [31:0] addr_q;
  logic [31:0] eff;
  logic [31:0] dn_addr;

  logic        io_q;
  logic        we_q;
  size_e       size_q;
  logic [1:0]  ofs_q;

  logic [3:0]  be_le, be_be, ue_le, ue_be;
  logic [31:0] wd_le, wd_be, rd_le, rd_be;

  assign hsize   = size_e'(h_size);
  assign h_ready = (state == ST_IDLE);
  assign accept  = h_req && h_ready;

  pcfg_decode #(
    .HA_W(HA_W), .PTR_OFS(PTR_OFS), .CFG_OFS(CFG_OFS), .IO_OFS(IO_OFS)
  ) u_dec (
    .addr(h_addr), .size(hsize), .tgt(tgt), .legal(legal), .lane(lane)
  );

  pcfg_ptr_reg #(.W(32), .RST_VAL(PTR_RST)) u_ptr (
    .clk(clk), .rst(rst),
    .wr_en(accept && legal && (tgt == TGT_PTR) && h_we),
    .wr_data(h_wdata), .q(addr_q)
  );

  assign eff     = {addr_q[31:2], 2'b00};
  assign dn_addr = (tgt == TGT_CFG) ? (eff | {30'd0, lane}) : (eff + {30'd0, lane});

  pcfg_lane_map #(.BIG(1'b0), .UNPACK(1'b0)) u_pk_le (
    .size(hsize), .ofs(lane), .din(h_wdata), .lane_en(be_le), .dout(wd_le));
  pcfg_lane_map #(.BIG(1'b1), .UNPACK(1'b0)) u_pk_be (
    .size(hsize), .ofs(lane), .din(h_wdata), .lane_en(be_be), .dout(wd_be));
  pcfg_lane_map #(.BIG(1'b0), .UNPACK(1'b1)) u_un_le (
    .size(size_q), .ofs(ofs_q), .din(d_rsp_rdata), .lane_en(ue_le), .dout(rd_le));
  pcfg_lane_map #(.BIG(1'b1), .UNPACK(1'b1)) u_un_be (
    .size(size_q), .ofs(ofs_q), .din(d_rsp_rdata), .lane_en(ue_be), .dout(rd_be));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      h_rsp_valid <= 1'b0;
      h_rsp_err   <= 1'b0;
      h_rdata     <= '0;
      d_req_valid <= 1'b0;
      d_req_io    <= 1'b0;
      d_req_we    <= 1'b0;
      d_req_addr  <= '0;
      d_req_be    <= '0;
      d_req_wdata <= '0;
      io_q        <= 1'b0;
      we_q        <= 1'b0;
      size_q      <= SZ_B;
      ofs_q       <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (h_req) begin
            if (!legal) begin
              h_rsp_valid <= 1'b1;
              h_rsp_err   <= 1'b1;
              h_rdata     <= '0;
              state       <= ST_DONE;
            end else if (tgt == TGT_PTR) begin
              h_rsp_valid <= 1'b1;
              h_rsp_err   <= 1'b0;
              h_rdata     <= h_we ? 32'h0 : addr_q;
              state       <= ST_DONE;
            end else begin
              d_req_valid <= 1'b1;
              d_req_io    <= (tgt == TGT_IO);
              d_req_we    <= h_we;
              d_req_addr  <= dn_addr;
              d_req_be    <= (tgt == TGT_IO) ? be_be : be_le;
              d_req_wdata <= !h_we ? 32'h0 : ((tgt == TGT_IO) ? wd_be : wd_le);
              io_q        <= (tgt == TGT_IO);
              we_q        <= h_we;
              size_q      <= hsize;
              ofs_q       <= lane;
              state       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          d_req_valid <= 1'b0;
          if (d_rsp_valid) begin
            h_rsp_valid <= 1'b1;
            h_rsp_err   <= 1'b0;
            h_rdata     <= we_q ? 32'h0 : (io_q ? rd_be : rd_le);
            state       <= ST_DONE;
          end
        end
        ST_DONE: begin
          h_rsp_valid <= 1'b0;
          h_rsp_err   <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{ue_le, ue_be};

endmodule

// File: rtl/pcfg_front_chk.sv
module pcfg_front_chk #(
  parameter int              HA_W    = 12,
  parameter logic [HA_W-1:0] PTR_OFS = 12'h064
) (
  input logic            clk,
  input logic            rst,
  input logic            h_req,
  input logic            h_ready,
  input logic            h_we,
  input logic [HA_W-1:0] h_addr,
  input logic [1:0]      h_size,
  input logic            h_rsp_valid,
  input logic            d_req_valid,
  input logic [31:0]     d_req_addr,
  input logic [3:0]      d_req_be,
  input logic [31:0]     ptr_q
);

  assert_req_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    d_req_valid |=> !d_req_valid);

  assert_rsp_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    h_rsp_valid |=> !h_rsp_valid);

  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_ready) |=> !h_ready);

  assert_req_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    d_req_valid |-> !h_ready);

  assert_be_count_R6: assert property (@(posedge clk) disable iff (rst)
    d_req_valid |-> ($countones(d_req_be) == 1 || $countones(d_req_be) == 2 ||
                     $countones(d_req_be) == 4));

  assert_be_first_lane_R6: assert property (@(posedge clk) disable iff (rst)
    d_req_valid |-> d_req_be[d_req_addr[1:0]]);

  assert_addr_from_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    d_req_valid |-> (d_req_addr[31:2] == ptr_q[31:2]));

  assert_ptr_bad_size_R2: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_ready && h_we && h_addr == PTR_OFS && h_size != 2'd2) |=> $stable(ptr_q));

endmodule

bind pcfg_front pcfg_front_chk #(.HA_W(HA_W), .PTR_OFS(PTR_OFS)) u_chk (
  .clk(clk), .rst(rst), .h_req(h_req), .h_ready(h_ready), .h_we(h_we),
  .h_addr(h_addr), .h_size(h_size), .h_rsp_valid(h_rsp_valid),
  .d_req_valid(d_req_valid), .d_req_addr(d_req_addr), .d_req_be(d_req_be),
  .ptr_q(addr_q)
);

// File: tb/tb_pcfg_front.sv
module tb_pcfg_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_req = 1'b0;
  logic        h_we = 1'b0;
  logic [11:0] h_addr = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_rsp_valid, h_rsp_err;
  logic [31:0] h_rdata;
  logic        d_req_valid, d_req_io, d_req_we;
  logic [31:0] d_req_addr, d_req_wdata;
  logic [3:0]  d_req_be;
  logic        d_rsp_valid = 1'b0;
  logic [31:0] d_rsp_rdata = '0;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] m_ptr = 32'h0;

  always #2 clk = ~clk;

  pcfg_front dut (
    .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_ready(h_ready),
    .h_rsp_valid(h_rsp_valid), .h_rsp_err(h_rsp_err), .h_rdata(h_rdata),
    .d_req_valid(d_req_valid), .d_req_io(d_req_io), .d_req_we(d_req_we),
    .d_req_addr(d_req_addr), .d_req_be(d_req_be), .d_req_wdata(d_req_wdata),
    .d_rsp_valid(d_rsp_valid), .d_rsp_rdata(d_rsp_rdata)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One host access with a behavioural expectation built from the requirements.
  task automatic xact(input string rq, input bit we, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input int lat, input logic [31:0] rsp);
    int nb, k, ln;
    bit legal, down, is_io;
    logic [11:0] word;
    logic [31:0] e_addr, e_wd, e_rd;
    logic [3:0]  e_be;
    nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    k    = int'(a[1:0]);
    word = a & 12'hFFC;
    is_io = (word == 12'h06C);
    down  = 1'b0;
    if (word == 12'h064) legal = (sz == 2'd2) && (k == 0);
    else if (word == 12'h068 || word == 12'h06C) begin
      legal = (nb != 0) && ((k % nb) == 0);
      down  = legal;
    end else legal = 1'b0;

    h_req = 1'b1; h_we = we; h_addr = a; h_size = sz; h_wdata = wd;
    tick();
    h_req = 1'b0;
    chk(rq, "ready low after take", {31'd0, h_ready}, 32'd0);

    if (!down) begin
      chk(rq, "no downstream request", {31'd0, d_req_valid}, 32'd0);
      chk(rq, "local response", {31'd0, h_rsp_valid}, 32'd1);
      chk(rq, "error flag", {31'd0, h_rsp_err}, {31'd0, !legal});
      chk(rq, "local rdata", h_rdata, (legal && !we) ? m_ptr : 32'h0);
      if (legal && we) m_ptr = wd;
    end else begin
      e_addr = is_io ? ((m_ptr & 32'hFFFF_FFFC) + 32'(k)) : ((m_ptr & 32'hFFFF_FFFC) | 32'(k));
      e_be = '0; e_wd = '0; e_rd = '0;
      for (int i = 0; i < nb; i++) begin
        ln = is_io ? (k + nb - 1 - i) : (k + i);
        e_be[ln] = 1'b1;
        e_wd[ln*8 +: 8] = wd[i*8 +: 8];
        e_rd[i*8 +: 8]  = rsp[ln*8 +: 8];
      end
      chk(rq, "request valid", {31'd0, d_req_valid}, 32'd1);
      chk(rq, "request type", {31'd0, d_req_io}, {31'd0, is_io});
      chk(rq, "request we", {31'd0, d_req_we}, {31'd0, we});
      chk(rq, "request addr", d_req_addr, e_addr);
      chk(rq, "byte enables", {28'd0, d_req_be}, {28'd0, e_be});
      if (we) chk(rq, "lane data", d_req_wdata, e_wd);
      chk(rq, "no early response", {31'd0, h_rsp_valid}, 32'd0);
      for (int c = 0; c < lat; c++) begin
        tick();
        chk(rq, "request single pulse", {31'd0, d_req_valid}, 32'd0);
        chk(rq, "wait for downstream", {31'd0, h_rsp_valid}, 32'd0);
      end
      d_rsp_valid = 1'b1; d_rsp_rdata = rsp;
      tick();
      d_rsp_valid = 1'b0; d_rsp_rdata = '0;
      chk(rq, "response after downstream", {31'd0, h_rsp_valid}, 32'd1);
      chk(rq, "response error", {31'd0, h_rsp_err}, 32'd0);
      chk(rq, "read data lanes", h_rdata, we ? 32'h0 : e_rd);
    end
    tick();
    chk(rq, "ready again", {31'd0, h_ready}, 32'd1);
    chk(rq, "response pulse ends", {31'd0, h_rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "ready", {31'd0, h_ready}, 32'd1);
    chk("R11", "rsp valid", {31'd0, h_rsp_valid}, 32'd0);
    chk("R11", "req valid", {31'd0, d_req_valid}, 32'd0);
    // R1 pointer read after reset, write, readback with low bits
    xact("R1", 1'b0, 12'h064, 2'd2, 32'h0, 0, 32'h0);
    xact("R1", 1'b1, 12'h064, 2'd2, 32'h8000_1A07, 0, 32'h0);
    xact("R1", 1'b0, 12'h064, 2'd2, 32'h0, 0, 32'h0);
    // R2 wrong size or position on the pointer
    xact("R2", 1'b1, 12'h064, 2'd0, 32'h1234_5678, 0, 32'h0);
    xact("R2", 1'b1, 12'h066, 2'd1, 32'h1234_5678, 0, 32'h0);
    xact("R2", 1'b0, 12'h064, 2'd2, 32'h0, 0, 32'h0);
    // R3 R7 configuration window, bit 31 set
    xact("R3", 1'b0, 12'h068, 2'd2, 32'h0, 2, 32'hA1B2_C3D4);
    xact("R7", 1'b1, 12'h06B, 2'd0, 32'h0000_005A, 0, 32'h0);
    xact("R7", 1'b0, 12'h06A, 2'd1, 32'h0, 1, 32'h1122_3344);
    // R3 bit 31 clear still issues
    xact("R3", 1'b1, 12'h064, 2'd2, 32'h0000_0813, 0, 32'h0);
    xact("R3", 1'b1, 12'h06A, 2'd1, 32'h0000_BEEF, 3, 32'h0);
    xact("R7", 1'b1, 12'h068, 2'd2, 32'hCAFE_F00D, 1, 32'h0);
    // R4 R8 IO window, big-endian lanes
    xact("R4", 1'b1, 12'h064, 2'd2, 32'h0000_03F9, 0, 32'h0);
    xact("R8", 1'b1, 12'h06E, 2'd1, 32'h0000_ABCD, 0, 32'h0);
    xact("R8", 1'b0, 12'h06C, 2'd2, 32'h0, 2, 32'h0102_0304);
    xact("R4", 1'b0, 12'h06D, 2'd0, 32'h0, 1, 32'h5566_7788);
    xact("R8", 1'b1, 12'h06C, 2'd2, 32'hDEAD_BEEF, 0, 32'h0);
    xact("R6", 1'b0, 12'h06F, 2'd0, 32'h0, 0, 32'h99AA_BBCC);
    // R5 illegal sizes and alignment
    xact("R5", 1'b0, 12'h06D, 2'd1, 32'h0, 0, 32'h0);
    xact("R5", 1'b1, 12'h06E, 2'd2, 32'h1, 0, 32'h0);
    xact("R5", 1'b0, 12'h069, 2'd1, 32'h0, 0, 32'h0);
    xact("R5", 1'b0, 12'h068, 2'd3, 32'h0, 0, 32'h0);
    // R10 unmapped offsets
    xact("R10", 1'b0, 12'h070, 2'd2, 32'h0, 0, 32'h0);
    xact("R10", 1'b1, 12'h000, 2'd2, 32'h5, 0, 32'h0);
    // R9 long latency and final pointer value
    xact("R9", 1'b0, 12'h068, 2'd0, 32'h0, 3, 32'h0000_7700);
    xact("R1", 1'b0, 12'h064, 2'd2, 32'h0, 0, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule